// File: doc/BRIEF.md
# Signed Radix-4 Booth Multiplier with Carry-Save Reduction

This block multiplies two signed two's-complement operands of an even, parameterised width and returns the exact product at twice that width. The multiplier operand is recoded into radix-4 signed digits, one for each pair of bits. Each digit picks zero, one or two times the multiplicand, either positive or negated. This gives half as many partial products as a plain shift-and-add array would. The partial products, plus one vector that collects the "+1" terms of the negated rows, are compressed by a chain of 3:2 carry-save rows. A single carry-propagate add then resolves them.

One parameter places a register stage between the carry-save reduction and the final adder. With the stage in place, a result and its valid flag appear one clock after the operands are offered. The stage loads only when valid is high, so the output holds still while no new operands arrive. With the stage removed, the product and valid flag follow the inputs combinationally. Both operands may change on every cycle. Neither one is treated as a fixed constant.

Top module: `booth_mult_csa`

## Requirements
- R1: For every pair of signed operands, `product` equals their exact two's-complement product at 2*WIDTH bits.
- R2: The most negative operand times itself gives +2^(2*WIDTH-2) (64 for WIDTH=4). The result does not wrap to a negative value.
- R3: When either operand is zero, `product` is zero.
- R4: With PIPE=1, `out_valid` in a cycle equals `in_valid` of the previous cycle, and the product of operands taken with valid high appears in that following cycle. With PIPE=0, `out_valid` equals `in_valid` in the same cycle.
- R5: With PIPE=1, a cycle with `in_valid` low leaves `product` unchanged in the next cycle.
- R6: While `rst_n` is low, `out_valid` is 0 and `product` is 0 (PIPE=1).
- R7: A nonzero product has its top bit `product[2*WIDTH-1]` set exactly when the operands have different sign bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stage |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands on `a_in` and `b_in` are to be multiplied |
| a_in | input | WIDTH | Signed multiplicand |
| b_in | input | WIDTH | Signed multiplier, recoded into radix-4 digits |
| out_valid | output | 1 | `product` holds a new result |
| product | output | 2*WIDTH | Signed full-width product |

## Verification
Every one of the 256 operand pairs of the 4-bit configuration is streamed back to back, with the multiplier operand changing on each cycle. This exercises every Booth digit code in each digit position, and shows that no row is wired for a fixed coefficient. The sweep includes the extreme corners: zero, the most negative value on either side, and that value squared. These corners separate a correct sign extension and negation "+1" from ones that are only right for small positive values. Idle cycles are inserted among the valid ones. They separate a register that holds its content from one that loads on every clock, and they confirm that the valid flag tracks the input with exactly one cycle of delay.

// File: rtl/booth_pkg.sv
// Package booth_pkg
// Shared types for the radix-4 Booth multiplier: the magnitude choice of a
// recoded digit and the digit record passed from encoder to row generator.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package booth_pkg;

    typedef enum logic [1:0] {
        MAG_ZERO = 2'd0,
        MAG_ONE  = 2'd1,
        MAG_TWO  = 2'd2
    } booth_mag_e;

    typedef struct packed {
        booth_mag_e mag;
        logic       neg;
    } booth_digit_t;

endpackage

// File: rtl/booth_digit_enc.sv
// Module booth_digit_enc
// Maps one overlapping triplet of multiplier bits {high, mid, low} to a
// signed radix-4 digit in {-2,-1,0,+1,+2}. Codes 000 and 111 both give zero
// and are never flagged negative. Purely combinational.
module booth_digit_enc
    import booth_pkg::*;
(
    input  logic [2:0]   triplet,
    output booth_digit_t digit
);

    // Decode the triplet into magnitude and sign.
    always_comb begin
        unique case (triplet)
            3'b000:  digit = '{mag: MAG_ZERO, neg: 1'b0};
            3'b001:  digit = '{mag: MAG_ONE,  neg: 1'b0};
            3'b010:  digit = '{mag: MAG_ONE,  neg: 1'b0};
            3'b011:  digit = '{mag: MAG_TWO,  neg: 1'b0};
            3'b100:  digit = '{mag: MAG_TWO,  neg: 1'b1};
            3'b101:  digit = '{mag: MAG_ONE,  neg: 1'b1};
            3'b110:  digit = '{mag: MAG_ONE,  neg: 1'b1};
            default: digit = '{mag: MAG_ZERO, neg: 1'b0};
        endcase
    end

endmodule

// File: rtl/booth_pp_gen.sv
// Module booth_pp_gen
// Builds one partial-product row. The multiplicand is sign-extended to the
// full product width, doubled if the digit asks for it, and bitwise inverted
// for a negative digit. The row is then shifted left by SHIFT bits. The "+1"
// that completes the negation is not added here: it is returned on neg_bit
// so that the caller can place it at bit SHIFT of a separate correction row.
module booth_pp_gen
    import booth_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int SHIFT = 0,
    localparam int PW   = 2 * WIDTH
) (
    input  logic [WIDTH-1:0] mcand,
    input  booth_digit_t     digit,
    output logic [PW-1:0]    row,
    output logic             neg_bit
);

    logic [PW-1:0] ext;
    logic [PW-1:0] mag_val;
    logic [PW-1:0] signed_val;

    // Sign-extend the multiplicand to the product width.
    always_comb ext = {{(PW-WIDTH){mcand[WIDTH-1]}}, mcand};

    // Select zero, one or two times the multiplicand.
    always_comb begin
        unique case (digit.mag)
            MAG_ONE: mag_val = ext;
            MAG_TWO: mag_val = {ext[PW-2:0], 1'b0};
            default: mag_val = '0;
        endcase
    end

    // Invert for negative digits, then align to the digit weight.
    always_comb begin
        signed_val = digit.neg ? ~mag_val : mag_val;
        row        = signed_val << SHIFT;
        neg_bit    = digit.neg;
    end

endmodule

// File: rtl/csa_row.sv
// Module csa_row
// One 3:2 carry-save row. Three addends are reduced to a sum vector and a
// carry vector whose total equals the total of the inputs, modulo 2^WIDTH.
// The carry out of the top bit is dropped because the product is taken
// modulo 2^WIDTH.
module csa_row #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic [WIDTH-1:0] z,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] carry
);

    logic [WIDTH-1:0] maj;

    // Bitwise full adders: sum bits, and majority bits moved up one weight.
    always_comb begin
        sum   = x ^ y ^ z;
        maj   = (x & y) | (x & z) | (y & z);
        carry = {maj[WIDTH-2:0], 1'b0};
    end

endmodule

// File: rtl/booth_mult_csa.sv
// Module booth_mult_csa (top)
// Signed WIDTH x WIDTH multiplier. Radix-4 Booth recoding of b_in gives
// WIDTH/2 rows. These rows and one correction row of negation "+1" bits are
// folded by a chain of 3:2 carry-save rows into a sum/carry pair. With
// PIPE=1 that pair is registered, loading only on in_valid, before the final
// carry-propagate add. With PIPE=0 the whole path is combinational.
// Assumes WIDTH is even and at least 2. Reset is synchronous, active low.
module booth_mult_csa
    import booth_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter bit PIPE  = 1'b1,
    localparam int PW   = 2 * WIDTH,
    localparam int NPP  = WIDTH / 2,
    localparam int NOPS = NPP + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    output logic             out_valid,
    output logic [PW-1:0]    product
);

    logic [WIDTH:0]       b_pad;
    booth_digit_t         digits [NPP];
    logic [PW-1:0]        ops    [NOPS];
    logic [NPP-1:0]       negs;
    logic [PW-1:0]        corr;
    logic [PW-1:0]        red_sum   [NOPS-1];
    logic [PW-1:0]        red_carry [NOPS-1];
    logic [PW-1:0]        cpa_sum;
    logic [PW-1:0]        cpa_carry;

    // Append the implicit zero below the multiplier LSB.
    always_comb b_pad = {b_in, 1'b0};

    // Recode each bit pair and build its shifted row.
    for (genvar i = 0; i < NPP; i++) begin : g_digit
        booth_digit_enc u_enc (
            .triplet (b_pad[2*i+2 -: 3]),
            .digit   (digits[i])
        );
        booth_pp_gen #(.WIDTH(WIDTH), .SHIFT(2*i)) u_pp (
            .mcand   (a_in),
            .digit   (digits[i]),
            .row     (ops[i]),
            .neg_bit (negs[i])
        );
    end

    // Place each negation "+1" at its row's least significant weight.
    always_comb begin
        corr = '0;
        for (int i = 0; i < NPP; i++) corr[2*i] = negs[i];
    end
    always_comb ops[NOPS-1] = corr;

    // Seed the reduction chain with the first two operands.
    always_comb begin
        red_sum[0]   = ops[0];
        red_carry[0] = ops[1];
    end

    // Fold every further operand in with one carry-save row.
    for (genvar k = 2; k < NOPS; k++) begin : g_csa
        csa_row #(.WIDTH(PW)) u_csa (
            .x     (red_sum[k-2]),
            .y     (red_carry[k-2]),
            .z     (ops[k]),
            .sum   (red_sum[k-1]),
            .carry (red_carry[k-1])
        );
    end

    // Optional register between reduction and final add.
    if (PIPE) begin : g_pipe
        logic [PW-1:0] sum_q;
        logic [PW-1:0] carry_q;
        logic          vld_q;

        // Capture the carry-save pair on valid; track valid on every clock.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sum_q   <= '0;
                carry_q <= '0;
                vld_q   <= 1'b0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) begin
                    sum_q   <= red_sum[NOPS-2];
                    carry_q <= red_carry[NOPS-2];
                end
            end
        end

        always_comb begin
            cpa_sum   = sum_q;
            cpa_carry = carry_q;
            out_valid = vld_q;
        end
    end else begin : g_comb
        // Pass the reduction result and valid straight through.
        always_comb begin
            cpa_sum   = red_sum[NOPS-2];
            cpa_carry = red_carry[NOPS-2];
            out_valid = in_valid;
        end
    end

    // Final carry-propagate add.
    always_comb product = cpa_sum + cpa_carry;

endmodule

// File: rtl/booth_mult_chk.sv
// Module booth_mult_chk
// Property checker bound to booth_mult_csa. It observes the ports only and
// compares them with a behavioural signed multiply and with the valid timing.
module booth_mult_chk #(
    parameter int WIDTH = 4,
    parameter bit PIPE  = 1'b1,
    localparam int PW   = 2 * WIDTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [WIDTH-1:0] a_in,
    input logic [WIDTH-1:0] b_in,
    input logic             out_valid,
    input logic [PW-1:0]    product
);

    logic signed [PW-1:0] ea;
    logic signed [PW-1:0] eb;
    logic signed [PW-1:0] ref_now;
    logic                 zero_in;
    logic                 sign_diff;

    // Behavioural reference for the present operands.
    always_comb begin
        ea        = PW'($signed(a_in));
        eb        = PW'($signed(b_in));
        ref_now   = ea * eb;
        zero_in   = (a_in == '0) || (b_in == '0);
        sign_diff = a_in[WIDTH-1] ^ b_in[WIDTH-1];
    end

    if (PIPE) begin : g_seq
        // R1: registered result matches the reference for the operands taken.
        p_exact_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> (product == $past(ref_now)));

        // R3: a zero operand yields a zero product.
        p_zero_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && zero_in) |=> (product == '0));

        // R4: valid appears exactly one cycle later.
        p_valid_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        p_no_spurious_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);

        // R5: an idle cycle leaves the product unchanged.
        p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(product));

        // R7: sign of a nonzero product follows the operand signs.
        p_sign_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !zero_in) |=> (product[PW-1] == $past(sign_diff)));
    end else begin : g_comb
        // R1, R3, R4, R7: combinational path checked in the same cycle.
        p_exact_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> (product == ref_now));
        p_zero_operand_r3: assert property (@(posedge clk) disable iff (!rst_n)
            zero_in |-> (product == '0));
        p_valid_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
        p_sign_rule_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !zero_in |-> (product[PW-1] == sign_diff));
    end

endmodule

bind booth_mult_csa booth_mult_chk #(.WIDTH(WIDTH), .PIPE(PIPE)) u_booth_mult_chk (.*);

// File: tb/test_booth_mult_csa.sv
// Scoreboard bench for booth_mult_csa (WIDTH=4, PIPE=1). A driver task pushes
// the expected product of each operand pair into a queue. A monitor pops one
// entry for each valid output and compares it.
module test_booth_mult_csa;

    localparam int W  = 4;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  a_in = '0;
    logic [W-1:0]  b_in = '0;
    logic          out_valid;
    logic [PW-1:0] product;

    int            errors = 0;
    int            checks = 0;
    logic [PW-1:0] exp_q [$];
    logic [PW-1:0] last_prod = '0;
    bit            monitor_on = 1'b0;
    bit            done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    booth_mult_csa #(.WIDTH(W), .PIPE(1'b1)) i_booth_mult_csa (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .a_in      (a_in),
        .b_in      (b_in),
        .out_valid (out_valid),
        .product   (product)
    );

    // Record one check and report a mismatch.
    task automatic check(input string req, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one operand pair and push its expected product.
    task automatic drive(input int a, input int b);
        int p;
        @(negedge clk);
        a_in     = W'(a);
        b_in     = W'(b);
        in_valid = 1'b1;
        p        = a * b;
        exp_q.push_back(PW'(p));
    endtask

    // Drive one idle cycle with scrambled operands.
    task automatic idle(input int a, input int b);
        @(negedge clk);
        a_in     = W'(a);
        b_in     = W'(b);
        in_valid = 1'b0;
    endtask

    // Monitor: just after each rising edge, check valid timing, pop and compare.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (monitor_on) begin
                // R4: out_valid mirrors the in_valid driven during the previous cycle.
                check("R4 valid latency", PW'(out_valid), PW'(in_valid));
                if (out_valid) begin
                    if (exp_q.size() == 0) begin
                        check("R4 unexpected result", product, '0);
                        errors += (product == '0) ? 1 : 0;
                    end else begin
                        logic [PW-1:0] e;
                        e = exp_q.pop_front();
                        if (e == PW'(64))
                            check("R2 most negative squared", product, e);
                        else if (e == '0)
                            check("R3 zero operand", product, e);
                        else begin
                            check("R1 exact product", product, e);
                            // R7: the sign bit of a nonzero product
                            check("R7 sign bit", PW'(product[PW-1]), PW'(e[PW-1]));
                        end
                    end
                end else begin
                    // R5: an idle cycle keeps the last product.
                    check("R5 hold when idle", product, last_prod);
                end
                last_prod = product;
            end
        end
    end

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // Stimulus: reset, exhaustive sweep with idle gaps, drain.
    initial begin
        repeat (3) @(negedge clk);
        // R6: reset values
        check("R6 reset valid", PW'(out_valid), '0);
        check("R6 reset product", product, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 after reset product", product, '0);
        monitor_on = 1'b1;
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                drive(a, b);
            end
            idle(a + 3, -a);
            idle(-a, a + 5);
        end
        // Corner repeats: the extreme square after zero and after a different pair.
        drive(0, 5);
        drive(-8, -8);
        drive(7, -8);
        drive(-8, 7);
        drive(-1, -1);
        idle(0, 0);
        idle(0, 0);
        @(negedge clk);
        monitor_on = 1'b0;
        // R4: every pushed result has been produced
        check("R4 queue drained", PW'(exp_q.size()), '0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule